// File: doc/BRIEF.md
# Saturating Byte Dot-Product Engine

This block takes two vectors of 64 bytes each, one read as unsigned and the other as signed, and returns their dot product as one signed 16-bit word. The data arrives as four beats on a valid/ready input stream. Each beat carries 16 unsigned bytes and 16 signed bytes. A last flag marks the fourth beat. For each beat the engine multiplies matching bytes and adds adjacent products in pairs, saturating each pair sum to signed 16 bits. This gives eight 16-bit lanes per beat, or 32 lanes per vector.

After the fourth beat the 32 lanes are reduced by a fixed tree. In each step, adjacent lanes are added with signed 16-bit saturation, so the lane count halves. Five steps leave one word. Saturation happens at every stage, so the result can differ from the exact sum. The result is held on an output valid/ready handshake, and a one-cycle done pulse marks its first cycle. A frame whose last flag does not fall on the fourth beat is dropped and reported.

Top module: `dotp_engine`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `s_ready` is 1 and `m_valid`, `m_done` and `frame_err` are 0.
- R2: Each pair sum u[2j]*s[2j] + u[2j+1]*s[2j+1] is clamped to the range -32768..32767 before any reduction. For example, bytes 255,255 times 127,127 give 32767, not 64770.
- R3: The 32 lanes are ordered beat 0 lanes 0..7 first, then beat 1 and so on. Each reduction step forms lane i as sat(lane 2i + lane 2i+1). The final word is that tree's result. For example, clamped lanes 32767, 32767, -32768, -32768 reduce to -1.
- R4: `m_valid` rises exactly five clock cycles after the edge that accepts the fourth beat. `m_done` is high for that first cycle only.
- R5: While `m_valid` is high and `m_ready` is low, `m_result` and `m_valid` hold. `s_ready` is low from the fourth accepted beat until the result is accepted.
- R6: If an accepted beat has `s_last` not equal to "this is the fourth beat", the frame is dropped. `frame_err` pulses in the next cycle, no result is emitted, and the next beat starts a new frame.
- R7: Cycles with `s_valid` low between beats do not change the result.
- R8: A synchronous reset in the middle of a frame discards the beats already taken. The next four beats form a complete new frame.
- R9: Byte k of each input word sits at bits [8k+7:8k]. `s_ubytes` bytes are unsigned and `s_sbytes` bytes are two's-complement. Pair j of a beat uses bytes 2j and 2j+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Engine can take a beat |
| s_last | input | 1 | Marks the fourth beat of a frame |
| s_ubytes | input | 128 | 16 unsigned bytes |
| s_sbytes | input | 128 | 16 signed bytes |
| m_valid | output | 1 | Result valid, held until accepted |
| m_ready | input | 1 | Consumer takes the result |
| m_result | output | 16 | Saturated signed dot product |
| m_done | output | 1 | One-cycle pulse on the first result cycle |
| frame_err | output | 1 | One-cycle pulse when a frame is dropped |

## Verification
The checker assumes that reset is high from time zero and that the consumer's `m_ready` is a clean level sampled at the rising edge. The bench drives every input on the falling edge, so the values are stable at the edge. It offers a beat only while `s_ready` is high, so no beat is presented during reduction or hold.

// File: rtl/dotp_pkg.sv
package dotp_pkg;

  localparam int LW = 16;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_REDUCE  = 2'd1,
    ST_HOLD    = 2'd2
  } dotp_state_t;

  function automatic logic [LW-1:0] sat16(input logic signed [19:0] v);
    if (v > 20'sd32767)       return 16'h7fff;
    else if (v < -20'sd32768) return 16'h8000;
    else                      return v[LW-1:0];
  endfunction

endpackage

// File: rtl/dotp_madd.sv
module dotp_madd #(
  parameter int BYTES = 16
) (
  input  logic [BYTES*8-1:0]          ub,
  input  logic [BYTES*8-1:0]          sb,
  output logic [(BYTES/2)*dotp_pkg::LW-1:0] pairs
);
  import dotp_pkg::*;
  localparam int PB = BYTES / 2;

  for (genvar j = 0; j < PB; j++) begin : g_pair
    logic signed [17:0] p0, p1;
    logic signed [19:0] sum;
    assign p0  = $signed({1'b0, ub[16*j +: 8]})   * $signed({sb[16*j+7], sb[16*j +: 8]});
    assign p1  = $signed({1'b0, ub[16*j+8 +: 8]}) * $signed({sb[16*j+15], sb[16*j+8 +: 8]});
    assign sum = 20'(p0) + 20'(p1);
    assign pairs[j*LW +: LW] = sat16(sum);
  end
endmodule

// File: rtl/dotp_halve.sv
module dotp_halve #(
  parameter int N = 32
) (
  input  logic [N*dotp_pkg::LW-1:0] din,
  output logic [N*dotp_pkg::LW-1:0] dout
);
  import dotp_pkg::*;

  for (genvar i = 0; i < N/2; i++) begin : g_add
    logic signed [LW-1:0] a, b;
    logic signed [19:0]   s;
    assign a = $signed(din[(2*i)*LW +: LW]);
    assign b = $signed(din[(2*i+1)*LW +: LW]);
    assign s = 20'(a) + 20'(b);
    assign dout[i*LW +: LW] = sat16(s);
  end
  for (genvar i = N/2; i < N; i++) begin : g_zero
    assign dout[i*LW +: LW] = '0;
  end
endmodule

// File: rtl/dotp_engine.sv
module dotp_engine #(
  parameter int BYTES = 16,
  parameter int BEATS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic                 s_last,
  input  logic [BYTES*8-1:0]   s_ubytes,
  input  logic [BYTES*8-1:0]   s_sbytes,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic [15:0]          m_result,
  output logic                 m_done,
  output logic                 frame_err
);
  import dotp_pkg::*;

  localparam int PB     = BYTES / 2;
  localparam int NL     = PB * BEATS;
  localparam int LEVELS = $clog2(NL);
  localparam int CW     = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int LVW    = $clog2(LEVELS + 1);
  localparam int PBW    = PB * LW;
  localparam int NLW    = NL * LW;

  dotp_state_t     st;
  logic [CW-1:0]   cnt;
  logic [LVW-1:0]  lvl;
  logic [NLW-1:0]  lanes;
  logic [PBW-1:0]  pairs;
  logic [NLW-1:0]  halved;
  logic            acc;
  logic            at_end;

  dotp_madd #(.BYTES(BYTES)) u_madd (
    .ub    (s_ubytes),
    .sb    (s_sbytes),
    .pairs (pairs)
  );

  dotp_halve #(.N(NL)) u_halve (
    .din  (lanes),
    .dout (halved)
  );

  assign s_ready = (st == ST_COLLECT);
  assign acc     = s_valid && s_ready;
  assign at_end  = (cnt == CW'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_COLLECT;
      cnt       <= '0;
      lvl       <= '0;
      lanes     <= '0;
      m_valid   <= 1'b0;
      m_result  <= '0;
      m_done    <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      m_done    <= 1'b0;
      frame_err <= 1'b0;
      case (st)
        ST_COLLECT: begin
          if (acc) begin
            if (s_last != at_end) begin
              frame_err <= 1'b1;
              cnt       <= '0;
              lanes     <= '0;
            end else begin
              lanes[cnt*PBW +: PBW] <= pairs;
              if (at_end) begin
                cnt <= '0;
                lvl <= '0;
                st  <= ST_REDUCE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
          end
        end
        ST_REDUCE: begin
          lanes <= halved;
          if (lvl == LVW'(LEVELS - 1)) begin
            m_result <= halved[LW-1:0];
            m_valid  <= 1'b1;
            m_done   <= 1'b1;
            st       <= ST_HOLD;
          end else begin
            lvl <= lvl + 1'b1;
          end
        end
        ST_HOLD: begin
          if (m_ready) begin
            m_valid <= 1'b0;
            lanes   <= '0;
            st      <= ST_COLLECT;
          end
        end
        default: st <= ST_COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/dotp_engine_chk.sv
module dotp_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        s_ready,
  input logic        m_valid,
  input logic        m_ready,
  input logic [15:0] m_result,
  input logic        m_done,
  input logic        frame_err
);
  // R1: outputs idle in the cycle after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (s_ready && !m_valid && !m_done && !frame_err));

  // R5: result held while the consumer stalls
  a_r5_hold_result: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_result)));

  // R5: no input accepted while a result is pending
  a_r5_busy_no_ready: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> !s_ready);

  // R4: done is a single-cycle pulse
  a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
    m_done |=> !m_done);

  // R4: done marks the rise of valid
  a_r4_done_on_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) |-> m_done);

  // R6: a dropped frame never produces a result
  a_r6_err_no_result: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> (!m_valid && !m_done));
endmodule

bind dotp_engine dotp_engine_chk u_chk (.*);

// File: tb/tb_dotp_engine.sv
module tb_dotp_engine;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         s_valid = 1'b0;
  logic         s_ready;
  logic         s_last = 1'b0;
  logic [127:0] s_ubytes = '0;
  logic [127:0] s_sbytes = '0;
  logic         m_valid;
  logic         m_ready = 1'b1;
  logic [15:0]  m_result;
  logic         m_done;
  logic         frame_err;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  dotp_engine dut (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready), .s_last(s_last),
    .s_ubytes(s_ubytes), .s_sbytes(s_sbytes), .m_valid(m_valid), .m_ready(m_ready),
    .m_result(m_result), .m_done(m_done), .frame_err(frame_err)
  );

  always #5 clk = ~clk;

  function automatic int sat(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int ref_dot(input logic [511:0] u, input logic [511:0] s);
    int ln[32];
    int n;
    for (int b = 0; b < 4; b++)
      for (int j = 0; j < 8; j++) begin
        int k;
        k = b*128 + 16*j;
        ln[b*8+j] = sat(int'(u[k +: 8]) * int'($signed(s[k +: 8])) +
                        int'(u[k+8 +: 8]) * int'($signed(s[k+8 +: 8])));
      end
    n = 32;
    while (n > 1) begin
      for (int i = 0; i < n/2; i++) ln[i] = sat(ln[2*i] + ln[2*i+1]);
      n = n / 2;
    end
    return ln[0];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // behavioural reference model, updated at each rising edge
  logic [511:0] mu = '0, ms = '0;
  int  mcnt = 0, mwait = 0;
  bit  mhold = 0;
  bit  exp_valid = 0, exp_done = 0, exp_err = 0;
  int  exp_res = 0;

  always @(posedge clk) begin
    if (rst) begin
      mcnt = 0; mwait = 0; mhold = 0;
      exp_valid = 0; exp_done = 0; exp_err = 0;
    end else begin
      exp_done = 0; exp_err = 0;
      if (mhold) begin
        if (m_ready) begin mhold = 0; exp_valid = 0; end
      end else if (mwait > 0) begin
        mwait--;
        if (mwait == 0) begin
          mhold = 1; exp_valid = 1; exp_done = 1;
          exp_res = ref_dot(mu, ms);
        end
      end else if (s_valid) begin
        if (s_last != (mcnt == 3)) begin
          exp_err = 1; mcnt = 0;
        end else begin
          mu[mcnt*128 +: 128] = s_ubytes;
          ms[mcnt*128 +: 128] = s_sbytes;
          if (mcnt == 3) begin mcnt = 0; mwait = 5; end
          else mcnt++;
        end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check(s_ready == (!mhold && mwait == 0), "R5 s_ready", int'(s_ready), int'(!mhold && mwait == 0));
      check(m_valid == exp_valid, "R4 m_valid", int'(m_valid), int'(exp_valid));
      check(m_done == exp_done, "R4 m_done", int'(m_done), int'(exp_done));
      check(frame_err == exp_err, "R6 frame_err", int'(frame_err), int'(exp_err));
      if (exp_valid)
        check(int'($signed(m_result)) == exp_res, "R3 m_result", int'($signed(m_result)), exp_res);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 60000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  logic [127:0] tu[4], ts[4];

  task automatic clear_vec();
    for (int b = 0; b < 4; b++) begin tu[b] = '0; ts[b] = '0; end
  endtask

  task automatic drive_beat(input logic [127:0] u, input logic [127:0] s, input bit last);
    while (!s_ready) @(negedge clk);
    s_valid = 1; s_last = last; s_ubytes = u; s_sbytes = s;
    @(negedge clk);
    s_valid = 0; s_last = 0;
  endtask

  task automatic send_vec(input int gap);
    for (int b = 0; b < 4; b++) begin
      drive_beat(tu[b], ts[b], b == 3);
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic get_result(input int exp, input string req);
    int n;
    n = 0;
    while (!m_valid && n < 50) begin @(negedge clk); n++; end
    check(m_valid && int'($signed(m_result)) == exp, req, int'($signed(m_result)), exp);
    @(negedge clk);
  endtask

  function automatic logic [511:0] flat(input bit uns);
    logic [511:0] f;
    for (int b = 0; b < 4; b++) f[b*128 +: 128] = uns ? tu[b] : ts[b];
    return f;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check(s_ready && !m_valid && !m_done && !frame_err, "R1 reset idle",
          int'({s_ready, m_valid, m_done, frame_err}), 8);
    rst = 0;
    @(negedge clk);
    check(s_ready && !m_valid, "R1 after reset", int'({s_ready, m_valid}), 2);

    // R9: byte positions and signedness: 3*-2 + 5*4 = 14
    clear_vec();
    tu[0][7:0] = 8'd3;  ts[0][7:0]  = 8'hFE;
    tu[0][15:8] = 8'd5; ts[0][15:8] = 8'h04;
    send_vec(0);
    get_result(14, "R9 byte order");

    // R9: pair 7 of beat 3 (bytes 14,15): 200*-1 + 1*100 = -100
    clear_vec();
    tu[3][119:112] = 8'd200; ts[3][119:112] = 8'hFF;
    tu[3][127:120] = 8'd1;   ts[3][127:120] = 8'd100;
    send_vec(0);
    get_result(-100, "R9 last pair");

    // R2: pair sum clamps to 32767
    clear_vec();
    tu[0][15:0] = 16'hFFFF; ts[0][15:0] = 16'h7F7F;
    send_vec(0);
    get_result(32767, "R2 pair clamp");

    // R3: clamped lanes 32767, -32768 reduce to -1
    tu[0][31:16] = 16'hFFFF; ts[0][31:16] = 16'h8080;
    send_vec(0);
    get_result(-1, "R3 tree order");

    // R3: lanes 32767, 32767, -32768, -32768 reduce to -1
    clear_vec();
    tu[0][63:0] = {64{1'b1}};
    ts[0][31:0] = 32'h7F7F7F7F; ts[0][63:32] = 32'h80808080;
    send_vec(0);
    get_result(-1, "R3 clamp per level");

    // R7: random frames with idle gaps
    for (int v = 0; v < 24; v++) begin
      for (int b = 0; b < 4; b++) begin
        tu[b] = {$urandom, $urandom, $urandom, $urandom};
        ts[b] = {$urandom, $urandom, $urandom, $urandom};
      end
      send_vec(v % 3);
      get_result(ref_dot(flat(1), flat(0)), "R7 gaps");
    end

    // R5: stalled consumer keeps the result
    clear_vec();
    tu[1][7:0] = 8'd10; ts[1][7:0] = 8'd7;
    m_ready = 0;
    send_vec(0);
    while (!m_valid) @(negedge clk);
    repeat (6) @(negedge clk);
    check(m_valid && int'($signed(m_result)) == 70 && !s_ready, "R5 hold",
          int'($signed(m_result)), 70);
    m_ready = 1;
    @(negedge clk);
    check(!m_valid && s_ready, "R5 release", int'(m_valid), 0);

    // R6: last on the second beat
    clear_vec();
    drive_beat(128'd1, 128'd1, 0);
    drive_beat(128'd1, 128'd1, 1);
    check(frame_err, "R6 early last", int'(frame_err), 1);
    tu[2][7:0] = 8'd9; ts[2][7:0] = 8'd9;
    send_vec(0);
    get_result(81, "R6 recover");

    // R6: fourth beat without last
    for (int b = 0; b < 4; b++) drive_beat(128'd3, 128'd3, 0);
    check(frame_err, "R6 missing last", int'(frame_err), 1);
    send_vec(1);
    get_result(81, "R6 recover2");

    // R8: reset in the middle of a frame
    drive_beat({128{1'b1}}, {16{8'h7F}}, 0);
    drive_beat({128{1'b1}}, {16{8'h7F}}, 0);
    rst = 1;
    @(negedge clk);
    rst = 0;
    send_vec(0);
    get_result(81, "R8 mid reset");

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule